// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This unit keeps the stack pointer of a small 8-bit processor core and produces the data-memory address for every stack access. The stack fills from high addresses toward low ones. A one-byte push writes at the location the pointer names and then moves the pointer down by one. A one-byte pop first moves the pointer up by one and then reads from there. A subroutine call or interrupt entry stores a three-byte return address as three writes on consecutive cycles, and a return reads it back the same way. In both cases the pointer moves by three.

The core's decoder raises one-cycle strobes for push, pop, call and return. It supplies the push byte and the return address, and it reads the popped bytes straight from the memory's read port. Software sees the pointer as a low byte register and a high byte register, and it can write either one through its own write strobe. On reset the pointer holds the last address of internal SRAM.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads the RAM_END parameter (0x08FF by default), busy_o is low, and neither mem_we_o nor mem_re_o is asserted.
- R2: An accepted push asserts mem_we_o in the same cycle, with mem_addr_o equal to the pointer and mem_wdata_o equal to push_data_i. The pointer is one lower in the next cycle.
- R3: An accepted pop asserts mem_re_o in the same cycle, with mem_addr_o equal to the pointer plus one. The pointer is one higher in the next cycle.
- R4: An accepted call produces three write cycles in a row, at addresses P, P-1 and P-2, where P is the starting pointer. The data are ret_addr_i bits 7:0, then 15:8, then 23:16, so the least significant byte sits at the highest address. The pointer ends at P-3.
- R5: An accepted return produces three read cycles in a row, at addresses P+1, P+2 and P+3. The pointer ends at P+3.
- R6: busy_o is high in the two cycles that follow the start of a call or return transfer. While busy_o is high, the push, pop, call and return strobes are ignored.
- R7: spl_we_i loads reg_wdata_i into pointer bits 7:0. sph_we_i loads the low SP_W-8 bits of reg_wdata_i into the pointer bits above bit 7. With SP_W=12, sp_o bits 15:12 always read zero.
- R8: A byte-register write takes priority over stack movement. When idle, any strobe in the same cycle is dropped: there is no memory access and the pointer takes the written value. During a transfer, the beat's access still happens, the written value replaces the pointer, and the remaining beats start from it.
- R9: When several strobes arrive together while idle, call wins over return, return over push, and push over pop.
- R10: The pointer wraps modulo 2^SP_W. A push at 0 leaves 0xFFF, and a pop at 0xFFF reads address 0 (defaults).
- R11: mem_we_o and mem_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | One-byte push strobe |
| pop_i | input | 1 | One-byte pop strobe |
| call_i | input | 1 | Return-address push strobe (call or interrupt entry) |
| ret_i | input | 1 | Return-address pop strobe (subroutine or interrupt return) |
| push_data_i | input | 8 | Byte stored by a push |
| ret_addr_i | input | 24 | Return address stored by a call |
| spl_we_i | input | 1 | Write strobe for the pointer low byte |
| sph_we_i | input | 1 | Write strobe for the pointer high byte |
| reg_wdata_i | input | 8 | Data for the byte-register writes |
| mem_addr_o | output | 16 | Data-memory address for the stack access |
| mem_wdata_o | output | 8 | Data-memory write byte |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_re_o | output | 1 | Data-memory read enable |
| sp_o | output | 16 | Current pointer, zero-extended |
| busy_o | output | 1 | High while a return-address transfer is in progress |

## Verification
The bound checker watches several rules on every cycle. Reads and writes are mutually exclusive. The unused high pointer bits stay zero. An idle push moves the pointer down by exactly one. A call's first beat writes the low return byte at the pointer. busy_o rises only after a call or return, and every busy cycle carries a memory access. An idle register write blocks any access in that cycle. Other behaviour needs the bench's scenarios to show it: the byte order and addresses of all three beats, strobes dropped while busy, strobe priority, a register write landing in the middle of a transfer, and wrap-around at both ends.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_CALL = 2'd1,
    XFER_RET  = 2'd2
  } xfer_e;

  typedef enum logic [2:0] {
    ACC_IDLE = 3'd0,
    ACC_PUSH = 3'd1,
    ACC_POP  = 3'd2,
    ACC_CALL = 3'd3,
    ACC_RET  = 3'd4
  } acc_e;
endpackage

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg #(
  parameter int          SP_W      = 12,
  parameter logic [15:0] RESET_VAL = 16'h08FF,
  localparam int         HI_W      = SP_W - 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [7:0]      wdata,
  input  logic            dec,
  input  logic            inc,
  output logic [SP_W-1:0] sp_q
);
  logic [SP_W-1:0] sp_d;
  logic            sp_en;

  always_comb begin
    sp_d  = sp_q;
    sp_en = lo_we | hi_we | dec | inc;
    if (lo_we || hi_we) begin
      if (lo_we) sp_d[7:0]      = wdata;
      if (hi_we) sp_d[SP_W-1:8] = wdata[HI_W-1:0];
    end else if (dec) begin
      sp_d = sp_q - SP_W'(1);
    end else if (inc) begin
      sp_d = sp_q + SP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RESET_VAL[SP_W-1:0];
    else if (sp_en) sp_q <= sp_d;
  end
endmodule

// File: rtl/sp_seq.sv
module sp_seq
  import sp_pkg::*;
#(
  parameter int  RET_BYTES = 3,
  localparam int CNT_W     = $clog2(RET_BYTES),
  localparam int RA_W      = 8 * RET_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_call,
  input  logic             start_ret,
  input  logic [RA_W-1:0]  ret_addr_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] beat_o,
  output xfer_e            kind_o,
  output logic [RA_W-1:0]  ra_hold_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RET_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  xfer_e            kind_q, kind_d;
  logic             ra_en;

  assign busy_o = (cnt_q != '0);
  assign beat_o = cnt_q;
  assign kind_o = kind_q;

  always_comb begin
    cnt_d  = cnt_q;
    kind_d = kind_q;
    ra_en  = 1'b0;
    if (start_call || start_ret) begin
      cnt_d  = CNT_W'(1);
      kind_d = start_call ? XFER_CALL : XFER_RET;
      ra_en  = start_call;
    end else if (busy_o) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        kind_d = XFER_NONE;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      kind_q <= XFER_NONE;
    end else begin
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ra_hold_o <= '0;
    else if (ra_en) ra_hold_o <= ret_addr_i;
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int          SP_W      = 12,
  parameter logic [15:0] RAM_END   = 16'h08FF,
  parameter int          RET_BYTES = 3,
  localparam int         RA_W      = 8 * RET_BYTES,
  localparam int         CNT_W     = $clog2(RET_BYTES),
  localparam int         NSLOT     = 1 << CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [7:0]      push_data_i,
  input  logic [RA_W-1:0] ret_addr_i,
  input  logic            spl_we_i,
  input  logic            sph_we_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [15:0]     mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [15:0]     sp_o,
  output logic            busy_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [SP_W-1:0]  sp_q;
  logic [CNT_W-1:0] beat, slot_sel;
  xfer_e            kind;
  logic [RA_W-1:0]  ra_hold, ra_src;
  logic [7:0]       slot [NSLOT];
  logic             reg_wr, start_call, start_ret, busy;
  acc_e             acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign reg_wr     = spl_we_i | sph_we_i;
  assign start_call = !busy && !reg_wr && call_i;
  assign start_ret  = !busy && !reg_wr && !call_i && ret_i;

  sp_seq #(.RET_BYTES(RET_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .start_call(start_call), .start_ret(start_ret),
    .ret_addr_i(ret_addr_i), .busy_o(busy), .beat_o(beat), .kind_o(kind),
    .ra_hold_o(ra_hold)
  );

  always_comb begin
    if (busy)            acc = (kind == XFER_CALL) ? ACC_CALL : ACC_RET;
    else if (reg_wr)     acc = ACC_IDLE;
    else if (call_i)     acc = ACC_CALL;
    else if (ret_i)      acc = ACC_RET;
    else if (push_i)     acc = ACC_PUSH;
    else if (pop_i)      acc = ACC_POP;
    else                 acc = ACC_IDLE;
  end

  assign ra_src   = busy ? ra_hold : ret_addr_i;
  assign slot_sel = busy ? beat : '0;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < RET_BYTES) begin : g_byte
      assign slot[g] = ra_src[8*g +: 8];
    end else begin : g_pad
      assign slot[g] = 8'h00;
    end
  end

  assign mem_we_o = (acc == ACC_PUSH) || (acc == ACC_CALL);
  assign mem_re_o = (acc == ACC_POP)  || (acc == ACC_RET);

  always_comb begin
    mem_addr_o = 16'(sp_q);
    if (mem_re_o) mem_addr_o = 16'(SP_W'(sp_q + SP_W'(1)));
    case (acc)
      ACC_CALL: mem_wdata_o = slot[slot_sel];
      ACC_PUSH: mem_wdata_o = push_data_i;
      default:  mem_wdata_o = 8'h00;
    endcase
  end

  sp_ptr_reg #(.SP_W(SP_W), .RESET_VAL(RAM_END)) u_ptr (
    .clk(clk), .rst_n(rst_n_int), .lo_we(spl_we_i), .hi_we(sph_we_i),
    .wdata(reg_wdata_i), .dec(mem_we_o), .inc(mem_re_o), .sp_q(sp_q)
  );

  assign sp_o   = 16'(sp_q);
  assign busy_o = busy;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int  SP_W = 12,
  parameter int  RA_W = 24,
  localparam logic [15:0] MASK = 16'((17'd1 << SP_W) - 17'd1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push_i,
  input logic            pop_i,
  input logic            call_i,
  input logic            ret_i,
  input logic [RA_W-1:0] ret_addr_i,
  input logic            spl_we_i,
  input logic            sph_we_i,
  input logic [15:0]     mem_addr_o,
  input logic [7:0]      mem_wdata_o,
  input logic            mem_we_o,
  input logic            mem_re_o,
  input logic [15:0]     sp_o,
  input logic            busy_o
);
  // R11
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  // R7
  hi_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_o >> SP_W) == 16'd0);

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !busy_o && !call_i && !ret_i && !spl_we_i && !sph_we_i)
    |=> sp_o == (($past(sp_o) - 16'd1) & MASK));

  // R4
  call_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !busy_o && !spl_we_i && !sph_we_i)
    |-> (mem_we_o && mem_addr_o == sp_o && mem_wdata_o == ret_addr_i[7:0]));

  // R6
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past((call_i || ret_i) && !spl_we_i && !sph_we_i));

  // R6
  busy_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (mem_we_o || mem_re_o));

  // R8
  regwr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (spl_we_i || sph_we_i)) |-> !(mem_we_o || mem_re_o));

  // R3
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !call_i && !ret_i && !busy_o && !spl_we_i && !sph_we_i)
    |-> (mem_re_o && mem_addr_o == ((sp_o + 16'd1) & MASK)));
endmodule

bind stack_ptr_unit sp_checker #(.SP_W(SP_W), .RA_W(RA_W)) u_sp_checker (
  .clk(clk), .rst_n(rst_n_int), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
  .ret_i(ret_i), .ret_addr_i(ret_addr_i), .spl_we_i(spl_we_i), .sph_we_i(sph_we_i),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
  .mem_re_o(mem_re_o), .sp_o(sp_o), .busy_o(busy_o)
);

// File: tb/stack_ptr_unit_bench.sv
`timescale 1ns/1ps
module stack_ptr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_i, pop_i, call_i, ret_i, spl_we_i, sph_we_i;
  logic [7:0]  push_data_i, reg_wdata_i;
  logic [23:0] ret_addr_i;
  logic [15:0] mem_addr_o, sp_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_we_o, mem_re_o, busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [11:0] m_sp;
  int          m_cnt;
  bit          m_call;
  logic [23:0] m_ra;

  always #2.5 clk = ~clk;

  stack_ptr_unit u_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
    .ret_i(ret_i), .push_data_i(push_data_i), .ret_addr_i(ret_addr_i),
    .spl_we_i(spl_we_i), .sph_we_i(sph_we_i), .reg_wdata_i(reg_wdata_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .sp_o(sp_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] next_sp(input logic [11:0] sp, input bit lw, input bit hw,
                                          input logic [7:0] rw, input bit wr, input bit rd);
    logic [11:0] n = sp;
    if (lw || hw) begin
      if (lw) n[7:0]  = rw;
      if (hw) n[11:8] = rw[3:0];
    end else if (wr) n = sp - 12'd1;
    else if (rd)     n = sp + 12'd1;
    return n;
  endfunction

  task automatic step(input bit pu, input bit po, input bit ca, input bit rt,
                      input logic [7:0] pd, input logic [23:0] ra,
                      input bit lw, input bit hw, input logic [7:0] rw, input string force_tag);
    bit e_we = 0, e_re = 0, st_c = 0, st_r = 0;
    logic [11:0] e_addr;
    logic [7:0]  e_wd = 8'h00;
    string tag = "R8";
    push_i = pu; pop_i = po; call_i = ca; ret_i = rt; push_data_i = pd; ret_addr_i = ra;
    spl_we_i = lw; sph_we_i = hw; reg_wdata_i = rw;
    #1;
    e_addr = m_sp;
    if (m_cnt != 0) begin
      if (m_call) begin e_we = 1; e_wd = m_ra[8*m_cnt +: 8]; tag = "R4"; end
      else begin e_re = 1; e_addr = m_sp + 12'd1; tag = "R5"; end
    end else if (!(lw || hw)) begin
      if (ca)      begin e_we = 1; e_wd = ra[7:0]; st_c = 1; tag = "R4"; end
      else if (rt) begin e_re = 1; e_addr = m_sp + 12'd1; st_r = 1; tag = "R5"; end
      else if (pu) begin e_we = 1; e_wd = pd; tag = "R2"; end
      else if (po) begin e_re = 1; e_addr = m_sp + 12'd1; tag = "R3"; end
      else tag = "R1";
    end
    if (force_tag != "") tag = force_tag;
    chk({mem_we_o, mem_re_o, mem_addr_o, mem_wdata_o} === {e_we, e_re, 4'h0, e_addr, e_wd},
        tag, {6'd0, mem_we_o, mem_re_o, mem_addr_o, mem_wdata_o},
        {6'd0, e_we, e_re, 4'h0, e_addr, e_wd});
    chk(sp_o === {4'h0, m_sp}, "R7", {16'd0, sp_o}, {20'd0, m_sp});
    chk(busy_o === (m_cnt != 0), "R6", {31'd0, busy_o}, {31'd0, m_cnt != 0});
    @(posedge clk);
    m_sp = next_sp(m_sp, lw, hw, rw, e_we, e_re);
    if (st_c || st_r) begin
      m_cnt = 1; m_call = st_c;
      if (st_c) m_ra = ra;
    end else if (m_cnt != 0) begin
      m_cnt = (m_cnt == 2) ? 0 : m_cnt + 1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input string t);
    step(0, 0, 0, 0, 8'h00, 24'h0, 0, 0, 8'h00, t);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0;
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0; spl_we_i = 0; sph_we_i = 0;
    push_data_i = 0; reg_wdata_i = 0; ret_addr_i = 0;
    m_sp = 12'h8FF; m_cnt = 0; m_call = 0; m_ra = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk(sp_o === 16'h08FF, "R1", {16'd0, sp_o}, 32'h08FF);
    chk({busy_o, mem_we_o, mem_re_o} === 3'b000, "R1", {29'd0, busy_o, mem_we_o, mem_re_o}, 32'd0);
    rst_n = 1;
    repeat (3) idle("R1");

    // R2 push then R3 pop
    step(1, 0, 0, 0, 8'hA5, 24'h0, 0, 0, 8'h00, "R2");
    chk(sp_o === 16'h08FE, "R2", {16'd0, sp_o}, 32'h08FE);
    step(0, 1, 0, 0, 8'h00, 24'h0, 0, 0, 8'h00, "R3");
    chk(sp_o === 16'h08FF, "R3", {16'd0, sp_o}, 32'h08FF);

    // R4 call, with a push strobe during the busy beat (R6)
    step(0, 0, 1, 0, 8'h00, 24'h123456, 0, 0, 8'h00, "R4");
    step(1, 1, 0, 0, 8'hEE, 24'h0, 0, 0, 8'h00, "R6");
    step(0, 0, 1, 1, 8'h00, 24'h0, 0, 0, 8'h00, "R6");
    chk(sp_o === 16'h08FC, "R4", {16'd0, sp_o}, 32'h08FC);
    // R5 return
    step(0, 0, 0, 1, 8'h00, 24'h0, 0, 0, 8'h00, "R5");
    idle("R5"); idle("R5");
    chk(sp_o === 16'h08FF, "R5", {16'd0, sp_o}, 32'h08FF);

    // R9 priority among simultaneous strobes
    step(1, 1, 1, 1, 8'h11, 24'hABCDEF, 0, 0, 8'h00, "R9");
    idle("R9"); idle("R9");
    step(1, 0, 0, 1, 8'h22, 24'h0, 0, 0, 8'h00, "R9");
    idle("R9"); idle("R9");
    step(1, 1, 0, 0, 8'h33, 24'h0, 0, 0, 8'h00, "R9");

    // R8 register write beats an idle push; R7 high byte masking
    step(1, 0, 0, 0, 8'h44, 24'h0, 1, 0, 8'h80, "R8");
    step(0, 0, 0, 0, 8'h00, 24'h0, 0, 1, 8'hF3, "R7");
    chk(sp_o === 16'h0380, "R7", {16'd0, sp_o}, 32'h0380);

    // R10 wrap at both ends
    step(0, 0, 0, 0, 8'h00, 24'h0, 1, 1, 8'h00, "R10");
    step(1, 0, 0, 0, 8'h5A, 24'h0, 0, 0, 8'h00, "R10");
    chk(sp_o === 16'h0FFF, "R10", {16'd0, sp_o}, 32'h0FFF);
    step(0, 1, 0, 0, 8'h00, 24'h0, 0, 0, 8'h00, "R10");
    chk(sp_o === 16'h0000, "R10", {16'd0, sp_o}, 32'h0000);

    // R8 register write in the middle of a call transfer
    step(0, 0, 0, 0, 8'h00, 24'h0, 1, 1, 8'h06, "R8");
    step(0, 0, 1, 0, 8'h00, 24'h778899, 0, 0, 8'h00, "R4");
    step(0, 0, 0, 0, 8'h00, 24'h0, 1, 0, 8'h40, "R8");
    idle("R8");
    chk(sp_o === 16'h063F, "R8", {16'd0, sp_o}, 32'h063F);

    // random mix, R11 covered by every access comparison
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit lw = (r < 3);
      bit hw = (r >= 3 && r < 5);
      step($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
           8'($urandom), 24'($urandom), lw, hw, 8'($urandom), "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule